// File: doc/BRIEF.md
# External Data Memory Access Controller

This block serves the data-memory transfers of an 8-bit CPU core. The core raises a request with a 16-bit address, a direction and write data. The controller sends the transfer either to a 1 KB on-chip SRAM or to an off-chip bus, and answers with a one-clock acknowledge and, for reads, the returned byte. An enable input picks the route. When it is set, the lowest 1 KB of the address space goes to the on-chip SRAM. When it is clear, every address goes off-chip.

The off-chip bus shares one 8-bit port between the low address byte and the data. An address-latch strobe marks the address phase, and the high address byte sits on its own port. Reads and writes use active-low read and write strobes. Time is counted in machine cycles of four clocks each. A 3-bit stretch setting makes an off-chip transfer last 2 to 9 machine cycles, and the extra cycles widen the read or write strobe. An on-chip transfer always takes 2 machine cycles.

Top module: `movx_ctrl`

## Requirements
- R1: While reset is applied and after it is released, `ack` is 0, `ale` is 0, `rd_n` and `wr_n` are 1, `ad_oe` is 0 and `sram_ce` is 0.
- R2: With `onchip_en`=1 and `addr` below 0x0400, the access goes to the SRAM. `sram_ce` pulses for exactly one clock, in clock 1 of the access. In that clock `sram_addr`=`addr[9:0]` and `sram_we`=`we`. Throughout the access `ale`=0, `rd_n`=`wr_n`=1 and `ad_oe`=0.
- R3: With `onchip_en`=0, every address goes off-chip, 0x0000–0x03FF included. With `onchip_en`=1, addresses from 0x0400 upward go off-chip. During an off-chip access `sram_ce` stays 0.
- R4: Clocks of an access are numbered from 0, where clock 0 is the clock after the edge that accepts `req`. An off-chip access with stretch value s (0..7) takes L=(s+2)*4 clocks, and `ack` is high in clock L-1.
- R5: An SRAM access takes 8 clocks, with `ack` in clock 7, whatever the stretch value.
- R6: In an off-chip access, `ale` is high only in clocks 1 and 2. `ad_oe`=1 and `ad_out`=`addr[7:0]` in clocks 0–3. `hi_addr`=`addr[15:8]` in every clock of the access.
- R7: In an off-chip write, `ad_oe`=1 and `ad_out`=`wdata` from clock 4 to L-1. `wr_n` is 0 exactly in clocks 5..L-2, and `rd_n` stays 1.
- R8: In an off-chip read, `ad_oe`=0 from clock 4 on, and `rd_n` is 0 exactly in clocks 5..L-2. `rdata` takes the `ad_in` value present in clock L-2, and `wr_n` stays 1.
- R9: `ack` is a single-clock pulse, and `rdata` holds the read result while `ack` is high.
- R10: The stretch value, address, direction and write data are captured when the access starts. Changing them later in the access changes neither its length nor its outputs.
- R11: An SRAM read returns the `sram_rdata` value presented in clock 2, which is the clock after `sram_ce`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| onchip_en | input | 1 | Routes the low 1 KB window to the SRAM |
| stretch | input | 3 | Off-chip length: stretch+2 machine cycles |
| req | input | 1 | Access request, held until ack |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | 16 | Access address |
| wdata | input | 8 | Write data |
| ack | output | 1 | One-clock completion pulse |
| rdata | output | 8 | Read result |
| sram_ce | output | 1 | SRAM select |
| sram_we | output | 1 | SRAM write enable |
| sram_addr | output | 10 | SRAM address |
| sram_wdata | output | 8 | SRAM write data |
| sram_rdata | input | 8 | SRAM read data, one clock after select |
| ad_out | output | 8 | Shared port: driven address/data |
| ad_oe | output | 1 | Shared port output enable |
| ad_in | input | 8 | Shared port: sampled data |
| hi_addr | output | 8 | High address byte |
| ale | output | 1 | Address latch strobe |
| rd_n | output | 1 | Active-low read strobe |
| wr_n | output | 1 | Active-low write strobe |

## Verification
The hardest case to reach from the ports is an access whose controls change while it is under way. The core is meant to hold its inputs stable, so ordinary traffic never shows whether the stretch value, address and data were captured at the start. One directed transfer flips all of them in clock 1 and then checks the length, the address phase and the data phase against the original values. The read sample point is a second hard case. The bench puts a fresh random byte on the shared port in every clock, so only a sample taken in exactly clock L-2 returns the expected value. Random stimulus with a fixed seed covers every stretch value on both routes, including addresses at the 0x03FF/0x0400 boundary.

// File: rtl/movx_pkg.sv
package movx_pkg;
  // Route of the access in progress
  typedef enum logic [1:0] {
    ROUTE_NONE = 2'd0,
    ROUTE_SRAM = 2'd1,
    ROUTE_BUS  = 2'd2
  } route_t;

  function automatic int unsigned access_clocks(int unsigned stretch_val,
                                                int unsigned min_mc,
                                                int unsigned phases);
    return (stretch_val + min_mc) * phases;
  endfunction
endpackage

// File: rtl/movx_decode.sv
module movx_decode #(
  parameter int ADDR_W = 16,
  parameter int WIN_AW = 10
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              onchip_en,
  output logic              go_bus
);
  logic in_window;

  always_comb begin
    in_window = (addr[ADDR_W-1:WIN_AW] == '0);
    go_bus    = !(onchip_en && in_window);
  end
endmodule

// File: rtl/movx_seq.sv
module movx_seq
  import movx_pkg::*;
#(
  parameter int STRETCH_W = 3,
  parameter int PHASES    = 4,
  parameter int MIN_MC    = 2,
  parameter int CNT_W     = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic                 go_bus,
  input  logic [STRETCH_W-1:0] stretch,
  output logic                 busy,
  output logic [CNT_W-1:0]     cnt,
  output logic [CNT_W-1:0]     last,
  output logic                 done
);
  logic                 busy_d;
  logic [CNT_W-1:0]     cnt_d;
  logic [CNT_W-1:0]     last_d;
  logic [CNT_W-1:0]     last_bus;
  logic [CNT_W-1:0]     last_sram;

  always_comb begin
    last_bus  = CNT_W'(access_clocks(int'(stretch), MIN_MC, PHASES) - 1);
    last_sram = CNT_W'(access_clocks(0, MIN_MC, PHASES) - 1);
    done      = busy && (cnt == last);
    busy_d    = busy;
    cnt_d     = cnt;
    last_d    = last;
    if (start) begin
      busy_d = 1'b1;
      cnt_d  = '0;
      last_d = go_bus ? last_bus : last_sram;
    end else if (done) begin
      busy_d = 1'b0;
      cnt_d  = '0;
    end else if (busy) begin
      cnt_d  = cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
      last <= '0;
    end else begin
      busy <= busy_d;
      cnt  <= cnt_d;
      last <= last_d;
    end
  end

  // R9
  ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R4
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> cnt <= last);

  // R10
  last_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> $stable(last));
endmodule

// File: rtl/movx_bus.sv
module movx_bus #(
  parameter int DATA_W = 8,
  parameter int PHASES = 4,
  parameter int CNT_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  input  logic              is_wr,
  input  logic [CNT_W-1:0]  cnt,
  input  logic [CNT_W-1:0]  last,
  input  logic [DATA_W-1:0] addr_lo,
  input  logic [DATA_W-1:0] wdata,
  output logic              ale,
  output logic [DATA_W-1:0] ad_out,
  output logic              ad_oe,
  output logic              rd_n,
  output logic              wr_n,
  output logic              sample
);
  localparam int ALE_LO   = 1;
  localparam int ALE_HI   = PHASES - 2;
  localparam int DATA_AT  = PHASES;
  localparam int STROBE_AT = PHASES + 1;

  logic addr_phase;
  logic strobe_win;

  always_comb begin
    addr_phase = (cnt < CNT_W'(DATA_AT));
    strobe_win = (cnt >= CNT_W'(STROBE_AT)) && (cnt < last);
    ale    = active && (cnt >= CNT_W'(ALE_LO)) && (cnt <= CNT_W'(ALE_HI));
    ad_oe  = active && (addr_phase || is_wr);
    ad_out = addr_phase ? addr_lo : wdata;
    rd_n   = !(active && !is_wr && strobe_win);
    wr_n   = !(active && is_wr && strobe_win);
    sample = active && !is_wr && (cnt == last - 1'b1);
  end

  // R7
  rd_wr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rd_n && !wr_n));

  // R8
  rd_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n |-> !ad_oe);

  // R7
  wr_driven_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_n |-> ad_oe);

  // R6
  ale_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ale |-> (ad_oe && rd_n && wr_n));
endmodule

// File: rtl/movx_sram_if.sv
module movx_sram_if #(
  parameter int DATA_W = 8,
  parameter int WIN_AW = 10,
  parameter int CNT_W  = 6
) (
  input  logic              active,
  input  logic              is_wr,
  input  logic [CNT_W-1:0]  cnt,
  input  logic [WIN_AW-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              ce,
  output logic              we,
  output logic [WIN_AW-1:0] saddr,
  output logic [DATA_W-1:0] swdata,
  output logic              capture
);
  localparam int SEL_AT = 1;
  localparam int CAP_AT = SEL_AT + 1;

  always_comb begin
    ce      = active && (cnt == CNT_W'(SEL_AT));
    we      = ce && is_wr;
    saddr   = addr;
    swdata  = wdata;
    capture = active && !is_wr && (cnt == CNT_W'(CAP_AT));
  end
endmodule

// File: rtl/movx_ctrl.sv
module movx_ctrl
  import movx_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 8,
  parameter int WIN_AW    = 10,
  parameter int STRETCH_W = 3,
  parameter int PHASES    = 4,
  parameter int MIN_MC    = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     onchip_en,
  input  logic [STRETCH_W-1:0]     stretch,
  input  logic                     req,
  input  logic                     we,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [DATA_W-1:0]        wdata,
  output logic                     ack,
  output logic [DATA_W-1:0]        rdata,
  output logic                     sram_ce,
  output logic                     sram_we,
  output logic [WIN_AW-1:0]        sram_addr,
  output logic [DATA_W-1:0]        sram_wdata,
  input  logic [DATA_W-1:0]        sram_rdata,
  output logic [DATA_W-1:0]        ad_out,
  output logic                     ad_oe,
  input  logic [DATA_W-1:0]        ad_in,
  output logic [ADDR_W-DATA_W-1:0] hi_addr,
  output logic                     ale,
  output logic                     rd_n,
  output logic                     wr_n
);
  localparam int MAX_CLK = (2**STRETCH_W - 1 + MIN_MC) * PHASES;
  localparam int CNT_W   = $clog2(MAX_CLK);

  // reset: asserted at once, released after two clock edges
  logic [1:0] rst_pipe;
  logic       rst_i_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_i_n = rst_pipe[1];

  logic              busy;
  logic              done;
  logic [CNT_W-1:0]  cnt;
  logic [CNT_W-1:0]  last;
  logic              go_bus;
  logic              start;

  route_t            route_q, route_d;
  logic              wr_q, wr_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [DATA_W-1:0] wdata_q, wdata_d;
  logic [DATA_W-1:0] rdata_q, rdata_d;
  logic              bus_sample;
  logic              sram_capture;

  movx_decode #(.ADDR_W(ADDR_W), .WIN_AW(WIN_AW)) i_decode (
    .addr      (addr),
    .onchip_en (onchip_en),
    .go_bus    (go_bus)
  );

  assign start = req && !busy;

  movx_seq #(
    .STRETCH_W (STRETCH_W),
    .PHASES    (PHASES),
    .MIN_MC    (MIN_MC),
    .CNT_W     (CNT_W)
  ) i_seq (
    .clk     (clk),
    .rst_n   (rst_i_n),
    .start   (start),
    .go_bus  (go_bus),
    .stretch (stretch),
    .busy    (busy),
    .cnt     (cnt),
    .last    (last),
    .done    (done)
  );

  always_comb begin
    route_d = route_q;
    wr_d    = wr_q;
    addr_d  = addr_q;
    wdata_d = wdata_q;
    if (start) begin
      route_d = go_bus ? ROUTE_BUS : ROUTE_SRAM;
      wr_d    = we;
      addr_d  = addr;
      wdata_d = wdata;
    end else if (done) begin
      route_d = ROUTE_NONE;
    end
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      route_q <= ROUTE_NONE;
      wr_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else begin
      route_q <= route_d;
      wr_q    <= wr_d;
      addr_q  <= addr_d;
      wdata_q <= wdata_d;
    end
  end

  movx_bus #(.DATA_W(DATA_W), .PHASES(PHASES), .CNT_W(CNT_W)) i_bus (
    .clk     (clk),
    .rst_n   (rst_i_n),
    .active  (busy && (route_q == ROUTE_BUS)),
    .is_wr   (wr_q),
    .cnt     (cnt),
    .last    (last),
    .addr_lo (addr_q[DATA_W-1:0]),
    .wdata   (wdata_q),
    .ale     (ale),
    .ad_out  (ad_out),
    .ad_oe   (ad_oe),
    .rd_n    (rd_n),
    .wr_n    (wr_n),
    .sample  (bus_sample)
  );

  movx_sram_if #(.DATA_W(DATA_W), .WIN_AW(WIN_AW), .CNT_W(CNT_W)) i_sram (
    .active  (busy && (route_q == ROUTE_SRAM)),
    .is_wr   (wr_q),
    .cnt     (cnt),
    .addr    (addr_q[WIN_AW-1:0]),
    .wdata   (wdata_q),
    .ce      (sram_ce),
    .we      (sram_we),
    .saddr   (sram_addr),
    .swdata  (sram_wdata),
    .capture (sram_capture)
  );

  always_comb begin
    rdata_d = rdata_q;
    if (bus_sample)        rdata_d = ad_in;
    else if (sram_capture) rdata_d = sram_rdata;
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) rdata_q <= '0;
    else          rdata_q <= rdata_d;
  end

  assign rdata   = rdata_q;
  assign ack     = done;
  assign hi_addr = addr_q[ADDR_W-1:DATA_W];

  // R2
  sram_bus_idle_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    (busy && route_q == ROUTE_SRAM) |-> (!ale && rd_n && wr_n && !ad_oe));

  // R3
  bus_no_sram_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    (busy && route_q == ROUTE_BUS) |-> !sram_ce);

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    !busy |-> (!ack && !ale && rd_n && wr_n && !ad_oe && !sram_ce));

  // R10
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    (busy && !done) |=> $stable(hi_addr));
endmodule

// File: tb/test_movx_ctrl.sv
module test_movx_ctrl;
  logic        clk;
  logic        rst_n;
  logic        onchip_en;
  logic [2:0]  stretch;
  logic        req;
  logic        we;
  logic [15:0] addr;
  logic [7:0]  wdata;
  logic        ack;
  logic [7:0]  rdata;
  logic        sram_ce;
  logic        sram_we;
  logic [9:0]  sram_addr;
  logic [7:0]  sram_wdata;
  logic [7:0]  sram_rdata;
  logic [7:0]  ad_out;
  logic        ad_oe;
  logic [7:0]  ad_in;
  logic [7:0]  hi_addr;
  logic        ale;
  logic        rd_n;
  logic        wr_n;

  int checks = 0;
  int errors = 0;
  logic [7:0] mem    [1024];
  logic [7:0] shadow [1024];

  movx_ctrl i_movx_ctrl (
    .clk(clk), .rst_n(rst_n), .onchip_en(onchip_en), .stretch(stretch),
    .req(req), .we(we), .addr(addr), .wdata(wdata), .ack(ack), .rdata(rdata),
    .sram_ce(sram_ce), .sram_we(sram_we), .sram_addr(sram_addr),
    .sram_wdata(sram_wdata), .sram_rdata(sram_rdata), .ad_out(ad_out),
    .ad_oe(ad_oe), .ad_in(ad_in), .hi_addr(hi_addr), .ale(ale),
    .rd_n(rd_n), .wr_n(wr_n)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // SRAM model with one clock of read latency
  always @(posedge clk) begin
    if (sram_ce) begin
      if (sram_we) mem[sram_addr] <= sram_wdata;
      sram_rdata <= mem[sram_addr];
    end
  end

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  function automatic bit routed_bus(input bit en, input logic [15:0] a);
    return !(en && a < 16'h0400);
  endfunction

  function automatic int exp_len(input bit bus, input logic [2:0] s);
    return bus ? (int'(s) + 2) * 4 : 8;
  endfunction

  task automatic access(input bit wr, input logic [15:0] a, input logic [7:0] d,
                        input logic [2:0] s, input bit en, input bit disturb);
    bit  bus;
    int  len;
    int  t;
    int  bad_idle, bad_addr, bad_wr, bad_rd, bad_sram;
    logic [7:0] exp_rd;
    logic [7:0] drv;
    bus = routed_bus(en, a);
    len = exp_len(bus, s);
    bad_idle = 0; bad_addr = 0; bad_wr = 0; bad_rd = 0; bad_sram = 0;
    exp_rd = 8'h00;
    @(negedge clk);
    onchip_en = en; stretch = s; we = wr; addr = a; wdata = d; req = 1'b1;
    t = 0;
    forever begin
      @(negedge clk);
      if (bus) begin
        if (sram_ce) bad_sram++;
        if (hi_addr !== a[15:8]) bad_addr++;
        if (ale !== (t == 1 || t == 2)) bad_addr++;
        if (t < 4 && (ad_oe !== 1'b1 || ad_out !== a[7:0])) bad_addr++;
        if (wr) begin
          if (t >= 4 && (ad_oe !== 1'b1 || ad_out !== d)) bad_wr++;
          if (wr_n !== !(t >= 5 && t <= len - 2)) bad_wr++;
          if (rd_n !== 1'b1) bad_wr++;
        end else begin
          if (t >= 4 && ad_oe !== 1'b0) bad_rd++;
          if (rd_n !== !(t >= 5 && t <= len - 2)) bad_rd++;
          if (wr_n !== 1'b1) bad_rd++;
        end
      end else begin
        if (ale !== 1'b0 || rd_n !== 1'b1 || wr_n !== 1'b1 || ad_oe !== 1'b0) bad_idle++;
        if (sram_ce !== (t == 1)) bad_sram++;
        if (t == 1 && (sram_addr !== a[9:0] || sram_we !== wr)) bad_sram++;
      end
      if (ack) break;
      if (t > 60) break;
      // R10: disturb the controls after the access has started
      if (disturb && t == 1) begin
        stretch = ~s; addr = ~a; wdata = ~d; we = ~wr; onchip_en = ~en;
      end
      drv = 8'($urandom);
      ad_in = drv;
      if (t == len - 2) exp_rd = drv;
      t++;
    end
    if (bus) begin
      chk(t == len - 1, "R4 ack clock", t, len - 1);
      chk(bad_addr == 0, "R6 address phase", bad_addr, 0);
      chk(bad_sram == 0, "R3 no sram select", bad_sram, 0);
      if (wr) chk(bad_wr == 0, "R7 write phase", bad_wr, 0);
      else begin
        chk(bad_rd == 0, "R8 read phase", bad_rd, 0);
        chk(rdata === exp_rd, "R8 read data", rdata, exp_rd);
      end
    end else begin
      chk(t == 7, "R5 sram length", t, 7);
      chk(bad_idle == 0, "R2 bus idle", bad_idle, 0);
      chk(bad_sram == 0, "R2 sram strobe", bad_sram, 0);
      if (wr) shadow[a[9:0]] = d;
      else chk(rdata === shadow[a[9:0]], "R11 sram read", rdata, shadow[a[9:0]]);
    end
    req = 1'b0;
    @(negedge clk);
    chk(ack === 1'b0, "R9 single ack", ack, 0);
  endtask

  initial begin
    void'($urandom(32'h5eed1234));
    for (int i = 0; i < 1024; i++) begin
      mem[i] = 8'h00;
      shadow[i] = 8'h00;
    end
    rst_n = 1'b0; req = 1'b0; we = 1'b0; addr = '0; wdata = '0;
    onchip_en = 1'b0; stretch = '0; ad_in = '0; sram_rdata = '0;
    repeat (3) @(negedge clk);
    chk(ack === 0 && ale === 0 && rd_n === 1 && wr_n === 1 && ad_oe === 0 && sram_ce === 0,
        "R1 reset outputs", {ack, ale, rd_n, wr_n, ad_oe, sram_ce}, 6'b001100);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(ack === 0 && ale === 0 && rd_n === 1 && wr_n === 1 && ad_oe === 0,
        "R1 after release", {ack, ale, rd_n, wr_n, ad_oe}, 5'b00110);

    access(1'b1, 16'h1234, 8'hA5, 3'd0, 1'b1, 1'b0); // R7 shortest write
    access(1'b0, 16'h8001, 8'h00, 3'd7, 1'b1, 1'b0); // R8 longest read
    access(1'b1, 16'h03FF, 8'h3C, 3'd7, 1'b1, 1'b0); // R5 sram write, top of window
    access(1'b0, 16'h03FF, 8'h00, 3'd5, 1'b1, 1'b0); // R11 sram read back
    access(1'b0, 16'h0010, 8'h00, 3'd1, 1'b0, 1'b0); // R3 window disabled
    access(1'b1, 16'h0400, 8'h77, 3'd2, 1'b1, 1'b0); // R3 just above window
    access(1'b1, 16'h4321, 8'h5A, 3'd3, 1'b1, 1'b1); // R10 disturbed write
    access(1'b0, 16'h0022, 8'h00, 3'd6, 1'b1, 1'b1); // R10 disturbed sram read

    for (int n = 0; n < 48; n++) begin
      logic [15:0] ra;
      ra = 16'($urandom);
      if ($urandom_range(0, 1) == 0) ra = {6'h00, ra[9:0]};
      access(1'($urandom), ra, 8'($urandom), 3'($urandom), 1'($urandom), 1'b0);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule